// File: doc/BRIEF.md
# Prioritised Interrupt Router with Claim/Complete

This block gathers level-sensitive interrupt lines from a set of sources and presents them to several processor contexts. Every source carries a small priority value. Every context has its own enable bitmap, its own priority threshold, and a claim/complete register. For each context the block continuously selects the best eligible source and raises that context's interrupt line whenever at least one exists.

Software services an interrupt in two steps. It reads the context's claim register, which returns the winning source number and takes that source out of the pending set. It then writes the same number back, which releases the source so that it can request again. Source number 0 is reserved: it is never pending, and a claim that returns 0 means the context has nothing to take.

All state is reached through a single 32-bit word-addressed request port. A request is accepted in any cycle in which `req_valid_i` is high, because `req_ready_o` is permanently high. Each accepted read produces exactly one response, `rsp_valid_o` with `rsp_data_o`, in the following cycle. Writes produce no response. The response has no ready signal, so the requester must take it in the cycle it appears.

Top module: `plic_core`

## Requirements
- R1: After reset all priorities, enable bits and thresholds are 0, nothing is pending or in service, every `irq_o` bit is low and `rsp_valid_o` is low.
- R2: Source 0 has no storage. Its priority word at byte offset 0x0 and its enable bit (bit 0 of enable word 0) always read 0, and writes to them are ignored.
- R3: Register placement. The priority of source n is at byte offset 4*n and holds 3 bits, with the upper bits reading 0. Context c's enable word w is at 0x2000 + 0x80*c + 4*w, and its bit b enables source 32*w + b. Context c's threshold is at 0x200000 + 0x1000*c, holds 3 bits, and has upper bits reading 0. Context c's claim/complete register is at 0x200000 + 0x1000*c + 4.
- R4: A read of any offset not listed in R3 (including misaligned offsets, nonexistent sources, contexts or enable words) returns 0, and a write to such an offset changes nothing.
- R5: `irq_o[c]` is high in the same cycle, combinationally, exactly when some pending source enabled for context c has a priority strictly greater than c's threshold. A threshold of 7 therefore masks the context.
- R6: A claim read returns the eligible source of context c with the highest priority. Among equal priorities the lowest source number wins. If no source is eligible the read returns 0. A nonzero result clears that source's pending state for all contexts.
- R7: A claimed source stays non-pending while it is in service, even if its level input stays high.
- R8: Writing source number n to context c's claim register, when n is enabled for c and in service, ends service. If the level is still high, the source is pending again one cycle after the completing write.
- R9: A completion write naming a source that is not enabled for that context, not in service, 0, or out of range has no effect.
- R10: `req_ready_o` is always high. Every accepted read gives `rsp_valid_o` high in the next cycle, and a cycle that follows a write or an idle cycle has `rsp_valid_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_lvl_i | input | NSRC-1 | Level request of sources 1..NSRC-1 (bit i is source i) |
| req_valid_i | input | 1 | Register request present |
| req_ready_o | output | 1 | Request accepted (always high) |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | AW | Byte offset of the register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Read data valid, one cycle after a read |
| rsp_data_o | output | 32 | Read data |
| irq_o | output | NCTX | Interrupt request per context |

## Verification
The bench builds the block with eight source numbers, two contexts and 3-bit priorities. With this shape every priority value and the fully masking threshold are reached. Ties among a few sources occur often, and a claim queue drains within a handful of reads. Because two contexts can enable the same source, the bench can show that a claim by one context removes the source from the other context's view. The small number of enable bits also lets random writes drive each context through both the empty state and the fully enabled state many times.

// File: rtl/plic_core_pkg.sv
package plic_core_pkg;
  localparam int unsigned PRIO_BASE  = 32'h0000_0000;
  localparam int unsigned EN_BASE    = 32'h0000_2000;
  localparam int unsigned EN_STRIDE  = 32'h0000_0080;
  localparam int unsigned CTX_BASE   = 32'h0020_0000;
  localparam int unsigned CTX_STRIDE = 32'h0000_1000;
  localparam int unsigned THR_OFF    = 32'h0;
  localparam int unsigned CLM_OFF    = 32'h4;
endpackage

// File: rtl/plic_gateway.sv
module plic_gateway (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);
  logic pend_q, busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      if (claim_i) begin
        pend_q <= 1'b0;
        busy_q <= 1'b1;
      end else if (level_i && !pend_q && !busy_q) begin
        pend_q <= 1'b1;
      end
      if (done_i) busy_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign busy_o = busy_q;

  // R6: only a pending source can be claimed, and a claim moves it into service
  p_claim_needs_pend_r6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |-> pend_q);
  p_claim_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    claim_i |=> (busy_q && !pend_q));
  // R7: no new request while in service
  p_hold_in_service_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !done_i) |=> !pend_q);
  // R8: completion ends service
  p_done_frees_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |=> !busy_q);
endmodule

// File: rtl/plic_pick.sv
module plic_pick #(
  parameter int NSRC = 8,
  parameter int PW   = 3,
  localparam int IDW = $clog2(NSRC)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          pend_i,
  input  logic [NSRC-1:0]          en_i,
  input  logic [NSRC-1:0][PW-1:0]  prio_i,
  input  logic [PW-1:0]            thr_i,
  output logic [IDW-1:0]           id_o,
  output logic                     req_o
);
  logic [PW-1:0] best_p;

  // Linear scan: a later source replaces the winner only with a strictly
  // higher priority, so ties go to the lowest number; seeding with the
  // threshold makes "strictly above threshold" fall out of the same compare.
  always_comb begin
    id_o   = '0;
    best_p = thr_i;
    for (int i = 1; i < NSRC; i++) begin
      if (pend_i[i] && en_i[i] && (prio_i[i] > best_p)) begin
        id_o   = IDW'(i);
        best_p = prio_i[i];
      end
    end
  end

  assign req_o = (id_o != '0);

  // R5/R6: a reported winner is pending, enabled and above threshold
  p_winner_eligible_r5: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> (pend_i[id_o] && en_i[id_o] && (prio_i[id_o] > thr_i)));
endmodule

// File: rtl/plic_core.sv
module plic_core
  import plic_core_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int NCTX = 2,
  parameter int PW   = 3,
  parameter int AW   = 26,
  localparam int IDW  = $clog2(NSRC),
  localparam int NWRD = (NSRC + 31) / 32,
  localparam int CW   = (NCTX > 1) ? $clog2(NCTX) : 1,
  localparam int WW   = (NWRD > 1) ? $clog2(NWRD) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:1] src_lvl_i,
  input  logic            req_valid_i,
  output logic            req_ready_o,
  input  logic            req_write_i,
  input  logic [AW-1:0]   req_addr_i,
  input  logic [31:0]     req_wdata_i,
  output logic            rsp_valid_o,
  output logic [31:0]     rsp_data_o,
  output logic [NCTX-1:0] irq_o
);
  logic [NSRC-1:0][PW-1:0] prio_q;
  logic [NCTX-1:0][NSRC-1:0] en_q;
  logic [NCTX-1:0][PW-1:0] thr_q;

  logic hit_prio, hit_en, hit_thr, hit_clm;
  logic [IDW-1:0] sel_src;
  logic [CW-1:0]  sel_ctx;
  logic [WW-1:0]  sel_wrd;
  logic [NSRC-1:0] word_hit;

  logic [NSRC-1:0] pend_all;
  logic [NSRC-1:1] busy_v, claim_v, done_v;
  logic [NCTX-1:0][IDW-1:0] win_id;
  logic rd_clm, wr_clm;
  logic [31:0] rd_val;
  logic rsp_valid_q;
  logic [31:0] rsp_data_q;

  assign req_ready_o = 1'b1;

  // address decode
  always_comb begin
    hit_prio = 1'b0;
    hit_en   = 1'b0;
    hit_thr  = 1'b0;
    hit_clm  = 1'b0;
    sel_src  = '0;
    sel_ctx  = '0;
    sel_wrd  = '0;
    for (int s = 0; s < NSRC; s++) begin
      if (req_addr_i == AW'(PRIO_BASE + 4 * s)) begin
        hit_prio = 1'b1;
        sel_src  = IDW'(s);
      end
    end
    for (int c = 0; c < NCTX; c++) begin
      for (int w = 0; w < NWRD; w++) begin
        if (req_addr_i == AW'(EN_BASE + EN_STRIDE * c + 4 * w)) begin
          hit_en  = 1'b1;
          sel_ctx = CW'(c);
          sel_wrd = WW'(w);
        end
      end
      if (req_addr_i == AW'(CTX_BASE + CTX_STRIDE * c + THR_OFF)) begin
        hit_thr = 1'b1;
        sel_ctx = CW'(c);
      end
      if (req_addr_i == AW'(CTX_BASE + CTX_STRIDE * c + CLM_OFF)) begin
        hit_clm = 1'b1;
        sel_ctx = CW'(c);
      end
    end
  end

  // which sources live in the addressed enable word (source 0 never)
  always_comb begin
    word_hit = '0;
    for (int s = 1; s < NSRC; s++) begin
      word_hit[s] = ((s / 32) == int'(sel_wrd));
    end
  end

  // configuration storage
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (req_valid_i && req_write_i) begin
      if (hit_prio && (sel_src != '0)) prio_q[sel_src] <= req_wdata_i[PW-1:0];
      if (hit_thr) thr_q[sel_ctx] <= req_wdata_i[PW-1:0];
      if (hit_en) begin
        for (int s = 1; s < NSRC; s++) begin
          if (word_hit[s]) en_q[sel_ctx][s] <= req_wdata_i[s % 32];
        end
      end
    end
  end

  // per-source gateways
  assign rd_clm = req_valid_i && !req_write_i && hit_clm;
  assign wr_clm = req_valid_i && req_write_i && hit_clm;
  assign pend_all[0] = 1'b0;

  for (genvar i = 1; i < NSRC; i++) begin : g_src
    assign claim_v[i] = rd_clm && (win_id[sel_ctx] == IDW'(i));
    assign done_v[i]  = wr_clm && (req_wdata_i == 32'(i)) && en_q[sel_ctx][i] && busy_v[i];
    plic_gateway u_gw (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (src_lvl_i[i]),
      .claim_i (claim_v[i]),
      .done_i  (done_v[i]),
      .pend_o  (pend_all[i]),
      .busy_o  (busy_v[i])
    );
  end

  // per-context selection
  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    plic_pick #(.NSRC(NSRC), .PW(PW)) u_pick (
      .clk    (clk),
      .rst_n  (rst_n),
      .pend_i (pend_all),
      .en_i   (en_q[c]),
      .prio_i (prio_q),
      .thr_i  (thr_q[c]),
      .id_o   (win_id[c]),
      .req_o  (irq_o[c])
    );

    // R5: a raised line implies an enabled pending source
    p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> |(pend_all & en_q[c]));
    // R5: the top threshold masks the context
    p_full_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_q[c] == '1) |-> !irq_o[c]);
  end

  // read mux
  always_comb begin
    rd_val = '0;
    if (hit_prio) begin
      rd_val[PW-1:0] = prio_q[sel_src];
    end else if (hit_en) begin
      for (int s = 1; s < NSRC; s++) begin
        if (word_hit[s]) rd_val[s % 32] = en_q[sel_ctx][s];
      end
    end else if (hit_thr) begin
      rd_val[PW-1:0] = thr_q[sel_ctx];
    end else if (hit_clm) begin
      rd_val[IDW-1:0] = win_id[sel_ctx];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= req_valid_i && !req_write_i;
      rsp_data_q  <= rd_val;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rsp_data_o  = rsp_data_q;

  // R10: one response per read, none for writes
  p_read_answers_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && !req_write_i) |=> rsp_valid_o);
  p_write_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i) |=> !rsp_valid_o);
  // R2: source 0 priority never takes a value
  p_src0_prio_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (prio_q[0] == '0));
endmodule

// File: tb/test_plic_core.sv
module test_plic_core;
  localparam int NSRC = 8;
  localparam int NCTX = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:1] src_lvl = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [25:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic [NCTX-1:0] irq;

  int checks = 0;
  int errors = 0;

  logic [2:0] m_prio [NSRC];
  logic [NSRC-1:0] m_en [NCTX];
  logic [2:0] m_thr [NCTX];
  logic [NSRC-1:0] m_pend, m_busy;
  logic [NSRC-1:0] lvl;
  logic [31:0] last_rd;

  always #10 clk = ~clk;

  plic_core #(.NSRC(NSRC), .NCTX(NCTX), .PW(3), .AW(26)) i_plic_core (
    .clk(clk), .rst_n(rst_n), .src_lvl_i(src_lvl),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data), .irq_o(irq));

  function automatic logic [25:0] a_prio(int n); return 26'(4 * n); endfunction
  function automatic logic [25:0] a_en(int c); return 26'(32'h2000 + 32'h80 * c); endfunction
  function automatic logic [25:0] a_thr(int c); return 26'(32'h200000 + 32'h1000 * c); endfunction
  function automatic logic [25:0] a_clm(int c); return 26'(32'h200004 + 32'h1000 * c); endfunction

  function automatic int m_best(int c);
    int best = 0;
    logic [2:0] bp = m_thr[c];
    for (int i = 1; i < NSRC; i++)
      if (m_pend[i] && m_en[c][i] && m_prio[i] > bp) begin best = i; bp = m_prio[i]; end
    return best;
  endfunction

  function automatic logic [31:0] m_read(logic [25:0] a);
    for (int s = 0; s < NSRC; s++) if (a == a_prio(s)) return 32'(m_prio[s]);
    for (int c = 0; c < NCTX; c++) begin
      if (a == a_en(c)) return 32'({m_en[c][NSRC-1:1], 1'b0});
      if (a == a_thr(c)) return 32'(m_thr[c]);
      if (a == a_clm(c)) return 32'(m_best(c));
    end
    return 32'h0;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_reset();
    for (int s = 0; s < NSRC; s++) m_prio[s] = '0;
    for (int c = 0; c < NCTX; c++) begin m_en[c] = '0; m_thr[c] = '0; end
    m_pend = '0; m_busy = '0;
  endtask

  // model of one clock edge, from the requirements
  task automatic m_step(input bit v, input bit w, input logic [25:0] a, input logic [31:0] d);
    int claim_id = 0;
    int done_id = 0;
    logic [NSRC-1:0] np = m_pend, nb = m_busy;
    for (int c = 0; c < NCTX; c++) begin
      if (v && !w && a == a_clm(c)) claim_id = m_best(c);
      if (v && w && a == a_clm(c))
        for (int i = 1; i < NSRC; i++)
          if (d == 32'(i) && m_en[c][i] && m_busy[i]) done_id = i;
    end
    for (int i = 1; i < NSRC; i++) begin
      if (i == claim_id) begin np[i] = 1'b0; nb[i] = 1'b1; end
      else if (lvl[i] && !m_pend[i] && !m_busy[i]) np[i] = 1'b1;
      if (i == done_id) nb[i] = 1'b0;
    end
    m_pend = np; m_busy = nb;
    if (v && w) begin
      for (int s = 1; s < NSRC; s++) if (a == a_prio(s)) m_prio[s] = d[2:0];
      for (int c = 0; c < NCTX; c++) begin
        if (a == a_en(c)) m_en[c] = {d[NSRC-1:1], 1'b0};
        if (a == a_thr(c)) m_thr[c] = d[2:0];
      end
    end
  endtask

  // one bus cycle; starts and ends at a falling edge
  task automatic op(input bit v, input bit w, input logic [25:0] a,
                    input logic [31:0] d, input string tag);
    logic [31:0] exp;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    src_lvl = lvl[NSRC-1:1];
    exp = m_read(a);
    @(posedge clk);
    m_step(v, w, a, d);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10 response valid", 32'(rsp_valid), 32'(v && !w));
    if (v && !w) chk(tag, rsp_data, exp);
    last_rd = rsp_data;
    for (int c = 0; c < NCTX; c++)
      chk("R5 irq line", 32'(irq[c]), 32'(m_best(c) != 0));
  endtask

  task automatic wr(input logic [25:0] a, input logic [31:0] d);
    op(1'b1, 1'b1, a, d, "write");
  endtask
  task automatic rd(input logic [25:0] a, input string tag);
    op(1'b1, 1'b0, a, 32'h0, tag);
  endtask
  task automatic idle();
    op(1'b0, 1'b0, 26'h0, 32'h0, "idle");
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    lvl = '0;
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 32'h0);
    chk("R1 rsp_valid after reset", 32'(rsp_valid), 32'h0);
    chk("R10 ready", 32'(req_ready), 32'h1);
    rd(a_prio(3), "R1 priority reset");
    rd(a_en(1), "R1 enable reset");
    rd(a_thr(0), "R1 threshold reset");
    rd(a_clm(0), "R1 claim empty");

    // R3 widths and placement
    wr(a_prio(1), 32'hFF);
    rd(a_prio(1), "R3 priority width");
    chk("R3 priority literal", last_rd, 32'h7);
    wr(a_en(1), 32'hFFFF_FFFF);
    rd(a_en(1), "R3 enable word");
    chk("R2 enable bit0 literal", last_rd, 32'hFE);
    wr(a_thr(1), 32'hABC);
    rd(a_thr(1), "R3 threshold width");
    // R2 source 0
    wr(a_prio(0), 32'h5);
    rd(a_prio(0), "R2 source 0 priority");
    chk("R2 source 0 literal", last_rd, 32'h0);
    // R4 unmapped
    wr(26'h1000, 32'h7);
    rd(26'h1000, "R4 unmapped read");
    rd(26'h6, "R4 misaligned read");
    wr(a_prio(NSRC), 32'h3);
    rd(a_prio(NSRC), "R4 nonexistent source");
    rd(a_en(2), "R4 nonexistent context");
    rd(26'h2004, "R4 nonexistent enable word");
    rd(a_prio(1), "R4 priority 1 untouched");

    // directed claim ordering, ties
    wr(a_thr(1), 32'h0);
    wr(a_en(1), 32'h0);
    wr(a_prio(1), 32'h0);
    wr(a_prio(2), 32'h3);
    wr(a_prio(3), 32'h5);
    wr(a_prio(5), 32'h5);
    wr(a_en(0), 32'hFE);
    lvl = 8'b0010_1100;
    idle(); idle();
    chk("R5 irq raised", 32'(irq[0]), 32'h1);
    rd(a_clm(0), "R6 claim tie");
    chk("R6 tie lowest number", last_rd, 32'h3);
    rd(a_clm(0), "R6 claim second");
    chk("R6 second", last_rd, 32'h5);
    rd(a_clm(0), "R6 claim third");
    chk("R6 third", last_rd, 32'h2);
    rd(a_clm(0), "R7 claim while in service");
    chk("R7 nothing while held", last_rd, 32'h0);
    chk("R7 irq low", 32'(irq[0]), 32'h0);
    // R9 ignored completions
    wr(a_clm(1), 32'h5);
    wr(a_clm(0), 32'h4);
    wr(a_clm(0), 32'h0);
    wr(a_clm(0), 32'h9);
    idle(); idle();
    rd(a_clm(0), "R9 ignored completion");
    chk("R9 still empty", last_rd, 32'h0);
    // R8 completion releases
    wr(a_clm(0), 32'h3);
    idle();
    chk("R8 re-pend irq", 32'(irq[0]), 32'h1);
    rd(a_clm(0), "R8 claim after complete");
    chk("R8 literal", last_rd, 32'h3);
    // R5 threshold strictness / full mask
    wr(a_clm(0), 32'h3); wr(a_clm(0), 32'h5); wr(a_clm(0), 32'h2);
    idle();
    wr(a_thr(0), 32'h5);
    chk("R5 priority equal to threshold", 32'(irq[0]), 32'h0);
    wr(a_thr(0), 32'h4);
    chk("R5 priority above threshold", 32'(irq[0]), 32'h1);
    wr(a_thr(0), 32'h7);
    chk("R5 full mask", 32'(irq[0]), 32'h0);
    wr(a_thr(0), 32'h0);
    // R11-style shared pending: claim by context 1 hides it from context 0
    lvl = 8'b0001_0000;
    wr(a_prio(4), 32'h6);
    wr(a_en(1), 32'h10);
    idle();
    rd(a_clm(1), "R6 claim on context 1");
    chk("R6 context 1 literal", last_rd, 32'h4);
    rd(a_clm(0), "R6 shared pending");
    chk("R6 not seen by context 0", 32'(last_rd == 32'h4), 32'h0);

    // random phase
    for (int it = 0; it < 600; it++) begin
      int k = int'($urandom % 7);
      int c = int'($urandom % NCTX);
      if (($urandom % 4) == 0) lvl = 8'($urandom) & 8'hFE;
      case (k)
        0: wr(a_prio(int'($urandom % (NSRC + 1))), $urandom);
        1: wr(a_en(c), $urandom);
        2: wr(a_thr(c), 32'($urandom % 8));
        3, 4: rd(a_clm(c), "R6 random claim");
        5: wr(a_clm(c), 32'($urandom % (NSRC + 2)));
        default: rd(26'($urandom % 16) << 2, "R3 random read");
      endcase
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule